// File: doc/BRIEF.md
# Byte Pointer Access Unit for 36-bit Word Memory

This block gives byte-granular access to a memory whose smallest addressable unit is a whole 36-bit word. A caller presents a pointer made of three parts: a word address, a byte width in bits, and a bit position counted from the least significant end of the word. The unit returns the selected field right-justified on a load, and on a deposit it replaces only the selected bits of the word. Bytes of any width from 1 to 36 bits work, so the common widths of 1, 6, 8, 9 and 18 bits are all covered.

The pointer can also be advanced. An advance moves the position up by the byte width. When the advanced byte would no longer fit in the word, the pointer moves to position 0 of the next word address. Combined operations first advance the pointer and then load or deposit through the new pointer, which makes walking a packed byte string a sequence of identical commands. The resulting pointer is returned with every response so that the caller can feed it back. The backing store is an internal synchronous word array. Each command takes a fixed number of cycles, and a one-cycle done pulse reports its result.

Top module: `bpu_unit`

## Requirements
- R1: After reset, cmd_ready is 1, done is 0, and rsp_byte, rsp_addr, rsp_pos and rsp_size are all 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. The done output is then 1 for exactly one cycle, two cycles after the accepting edge. cmd_ready is 0 in the two cycles in between.
- R3: A load returns (word >> pos) AND (2^size − 1) on rsp_byte, right-justified, with every bit above the field equal to 0. For example, with 9-bit bytes this is (word >> pos) AND 0x1FF.
- R4: A deposit writes the low size bits of cmd_wdata into bits pos .. pos+size−1 of the addressed word and leaves every other bit of that word unchanged.
- R5: An advance sets pos to pos+size. If the new pos + size exceeds 36, pos becomes 0 and the address becomes address+1, modulo the memory depth (16 words by default). This holds for byte widths 1, 6, 8, 9 and 18.
- R6: Combined advance-and-load and advance-and-deposit access memory through the advanced pointer. Plain load and plain deposit use the pointer as given and report it back unchanged.
- R7: A plain advance leaves memory unchanged. Every command other than a load reports rsp_byte = 0.
- R8: cmd_op encoding: 0 = advance, 1 = load, 2 = deposit, 3 = advance-and-load, 4 = advance-and-deposit. Codes 5 to 7 return the pointer unchanged, write nothing, and report rsp_byte = 0.
- R9: cmd_valid is ignored while cmd_ready is 0. Memory is not changed by such a request.
- R10: After reset, every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code (see R8) |
| cmd_addr | input | ADDR_W | Pointer word address |
| cmd_pos | input | POS_W | Pointer bit position from the LSB |
| cmd_size | input | POS_W | Pointer byte width in bits |
| cmd_wdata | input | WORD_W | Deposit data, right-justified |
| cmd_ready | output | 1 | Unit idle, can accept a command |
| done | output | 1 | One-cycle completion pulse |
| rsp_byte | output | WORD_W | Loaded byte, right-justified |
| rsp_addr | output | ADDR_W | Resulting pointer address |
| rsp_pos | output | POS_W | Resulting pointer position |
| rsp_size | output | POS_W | Pointer byte width |

## Verification
Every result of this block appears together with the done pulse. That pulse comes on the third rising edge counted from the accepting edge: the first edge latches the command and the advanced pointer, the second reads the word, and the third writes the field back or registers the loaded byte. The bench stamps each expected item with the cycle count at which it drives the command. The monitor samples on falling edges and compares both the data and the cycle of done against that stamp plus three. Memory effects such as field preservation, writes that must not happen, and ignored requests are checked through later whole-word loads, after the write cycle of the command under test.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [2:0] {
        OP_ADV      = 3'd0,
        OP_LOAD     = 3'd1,
        OP_DEP      = 3'd2,
        OP_ADV_LOAD = 3'd3,
        OP_ADV_DEP  = 3'd4
    } bpu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RESP = 2'd2
    } bpu_state_e;

endpackage

// File: rtl/bpu_advance.sv
module bpu_advance #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 4,
    parameter int POS_W  = 6
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [POS_W-1:0]  size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [POS_W-1:0]  pos_o
);
    localparam int SUM_W = POS_W + 2;

    logic [SUM_W-1:0] step_sum;
    logic [SUM_W-1:0] reach;

    always_comb begin
        step_sum = SUM_W'(pos_i) + SUM_W'(size_i);
        reach    = step_sum + SUM_W'(size_i);
        addr_o   = addr_i;
        pos_o    = pos_i;
        if (en) begin
            if (reach > SUM_W'(WORD_W)) begin
                addr_o = addr_i + ADDR_W'(1);
                pos_o  = '0;
            end else begin
                pos_o  = step_sum[POS_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bpu_field.sv
module bpu_field #(
    parameter int WORD_W = 36,
    parameter int POS_W  = 6
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [POS_W-1:0]  size_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] field_o,
    output logic [WORD_W-1:0] merged_o
);
    logic [WORD_W-1:0] low_mask;
    logic [WORD_W-1:0] placed_mask;

    always_comb begin
        if (int'(size_i) >= WORD_W) low_mask = '1;
        else                        low_mask = ~({WORD_W{1'b1}} << size_i);
        placed_mask = low_mask << pos_i;
        field_o     = (word_i >> pos_i) & low_mask;
        merged_o    = (word_i & ~placed_mask) | ((wdata_i & low_mask) << pos_i);
    end
endmodule

// File: rtl/bpu_unit.sv
module bpu_unit #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 4,
    parameter int POS_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [POS_W-1:0]  cmd_pos,
    input  logic [POS_W-1:0]  cmd_size,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [WORD_W-1:0] rsp_byte,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [POS_W-1:0]  rsp_pos,
    output logic [POS_W-1:0]  rsp_size
);
    import bpu_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        bpu_state_e        state;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic [POS_W-1:0]  size;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rbyte;
        logic              done;
    } bpu_regs_t;

    bpu_regs_t s_d, s_q;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              mem_we;
    logic [WORD_W-1:0] mem_wd;

    logic              adv_en;
    logic [ADDR_W-1:0] adv_addr;
    logic [POS_W-1:0]  adv_pos;
    logic [WORD_W-1:0] field_val;
    logic [WORD_W-1:0] merged_val;
    logic              is_load_q;
    logic              is_dep_q;

    assign adv_en = (cmd_op == OP_ADV) || (cmd_op == OP_ADV_LOAD) || (cmd_op == OP_ADV_DEP);

    bpu_advance #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_W(POS_W)) adv_i (
        .en     (adv_en),
        .addr_i (cmd_addr),
        .pos_i  (cmd_pos),
        .size_i (cmd_size),
        .addr_o (adv_addr),
        .pos_o  (adv_pos)
    );

    bpu_field #(.WORD_W(WORD_W), .POS_W(POS_W)) fld_i (
        .word_i   (s_q.word),
        .pos_i    (s_q.pos),
        .size_i   (s_q.size),
        .wdata_i  (s_q.wdata),
        .field_o  (field_val),
        .merged_o (merged_val)
    );

    assign is_load_q = (s_q.op == OP_LOAD) || (s_q.op == OP_ADV_LOAD);
    assign is_dep_q  = (s_q.op == OP_DEP)  || (s_q.op == OP_ADV_DEP);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        mem_we   = 1'b0;
        mem_wd   = merged_val;
        case (s_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.state = ST_READ;
                    s_d.op    = cmd_op;
                    s_d.addr  = adv_addr;
                    s_d.pos   = adv_pos;
                    s_d.size  = cmd_size;
                    s_d.wdata = cmd_wdata;
                end
            end
            ST_READ: begin
                s_d.word  = mem_q[s_q.addr];
                s_d.state = ST_RESP;
            end
            ST_RESP: begin
                s_d.done  = 1'b1;
                s_d.state = ST_IDLE;
                s_d.rbyte = is_load_q ? field_val : '0;
                mem_we    = is_dep_q;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            mem_q[s_q.addr] <= mem_wd;
        end
    end

    assign cmd_ready = (s_q.state == ST_IDLE);
    assign done      = s_q.done;
    assign rsp_byte  = s_q.rbyte;
    assign rsp_addr  = s_q.addr;
    assign rsp_pos   = s_q.pos;
    assign rsp_size  = s_q.size;

    // R2: fixed response timing and busy window
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!done && !cmd_ready) ##1 (!done && !cmd_ready) ##1 (done && cmd_ready));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: loaded byte is right-justified, nothing above the field
    assert_load_justified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && int'(rsp_size) < WORD_W) |-> ((rsp_byte >> rsp_size) == '0));

    // R5: address moves by at most one word per command
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> ##1
        ((rsp_addr == $past(cmd_addr, 2)) || (rsp_addr == ADDR_W'($past(cmd_addr, 2) + 1'b1))));

endmodule

// File: tb/bpu_unit_tb.sv
module bpu_unit_tb_top;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 4;
    localparam int POS_W  = 6;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [POS_W-1:0]  cmd_pos = '0;
    logic [POS_W-1:0]  cmd_size = '0;
    logic [WORD_W-1:0] cmd_wdata = '0;
    logic              cmd_ready, done;
    logic [WORD_W-1:0] rsp_byte;
    logic [ADDR_W-1:0] rsp_addr;
    logic [POS_W-1:0]  rsp_pos, rsp_size;

    bpu_unit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_W(POS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_pos(cmd_pos), .cmd_size(cmd_size),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done),
        .rsp_byte(rsp_byte), .rsp_addr(rsp_addr), .rsp_pos(rsp_pos), .rsp_size(rsp_size)
    );

    always #5 clk = ~clk;

    typedef struct {
        string             tag;
        logic [WORD_W-1:0] byt;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic [POS_W-1:0]  size;
        int                due;
    } exp_t;

    exp_t              sb_q[$];
    logic [WORD_W-1:0] model_mem [DEPTH];
    int                cyc = 0;
    int                checks = 0;
    int                errors = 0;
    logic [ADDR_W-1:0] last_addr;
    logic [POS_W-1:0]  last_pos;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_byte == e.byt && rsp_addr == e.addr && rsp_pos == e.pos && rsp_size == e.size,
                      e.tag, "byte/addr/pos/size",
                      {rsp_byte, rsp_addr, rsp_pos, rsp_size}, {e.byt, e.addr, e.pos, e.size});
                check(cyc == e.due, "R2", "done cycle", cyc, e.due);
            end
        end
    end

    // driver: computes expected result from the requirements, then drives
    task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                         input logic [POS_W-1:0] p, input logic [POS_W-1:0] s,
                         input logic [WORD_W-1:0] wd, input string tag);
        exp_t              e;
        logic [ADDR_W-1:0] na;
        logic [POS_W-1:0]  np;
        longint unsigned   mask;
        logic [WORD_W-1:0] fmask;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        na = a;
        np = p;
        if (op == 3'd0 || op == 3'd3 || op == 3'd4) begin
            if (int'(p) + 2 * int'(s) > WORD_W) begin
                na = a + 1'b1;
                np = '0;
            end else begin
                np = p + s;
            end
        end
        mask  = (s >= 36) ? 64'hF_FFFF_FFFF : ((64'd1 << s) - 1);
        fmask = WORD_W'(mask << np);
        e.tag  = tag;
        e.addr = na;
        e.pos  = np;
        e.size = s;
        e.byt  = '0;
        e.due  = cyc + 3;
        if (op == 3'd1 || op == 3'd3)
            e.byt = WORD_W'((64'(model_mem[na]) >> np) & mask);
        if (op == 3'd2 || op == 3'd4)
            model_mem[na] = (model_mem[na] & ~fmask) | (WORD_W'(64'(wd) & mask) << np);
        sb_q.push_back(e);
        last_addr = na;
        last_pos  = np;
        cmd_op = op; cmd_addr = a; cmd_pos = p; cmd_size = s; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [ADDR_W-1:0] pa;
        logic [POS_W-1:0]  pp;
        for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        check(done == 1'b0, "R1", "done", done, 0);
        check(rsp_byte == '0 && rsp_addr == '0 && rsp_pos == '0 && rsp_size == '0,
              "R1", "rsp fields", rsp_byte, 0);
        rst_n = 1'b1;

        // R10: memory cleared
        issue(3'd1, 4'd3, 6'd0, 6'd36, '0, "R10");
        issue(3'd1, 4'd15, 6'd0, 6'd36, '0, "R10");

        // R4: whole-word deposit, then R3: 9-bit field loads
        issue(3'd2, 4'd0, 6'd0, 6'd36, 36'h9_8765_4321, "R4");
        for (int k = 0; k < 4; k++) issue(3'd1, 4'd0, 6'(9 * k), 6'd9, '0, "R3");
        issue(3'd1, 4'd0, 6'd4, 6'd6, '0, "R3");

        // R4: partial deposit preserves neighbouring bits
        issue(3'd2, 4'd0, 6'd12, 6'd6, 36'hF_FFFF_FFAB, "R4");
        issue(3'd1, 4'd0, 6'd0, 6'd36, '0, "R4");

        // R6 + R5: advance-and-load walk across a word boundary
        pa = 4'd0; pp = 6'd0;
        for (int k = 0; k < 4; k++) begin
            issue(3'd3, pa, pp, 6'd9, '0, "R6");
            pa = last_addr; pp = last_pos;
        end

        // R5: advance with each supported width, including wraps
        issue(3'd0, 4'd5, 6'd24, 6'd6, '0, "R5");
        issue(3'd0, 4'd5, 6'd30, 6'd6, '0, "R5");
        issue(3'd0, 4'd5, 6'd16, 6'd8, '0, "R5");
        issue(3'd0, 4'd5, 6'd24, 6'd8, '0, "R5");
        issue(3'd0, 4'd5, 6'd34, 6'd1, '0, "R5");
        issue(3'd0, 4'd5, 6'd35, 6'd1, '0, "R5");
        issue(3'd0, 4'd5, 6'd0, 6'd18, '0, "R5");
        issue(3'd0, 4'd5, 6'd18, 6'd18, '0, "R5");
        issue(3'd0, 4'd15, 6'd27, 6'd9, '0, "R5");

        // R7: plain advance leaves memory alone
        issue(3'd0, 4'd0, 6'd0, 6'd9, '0, "R7");
        issue(3'd1, 4'd0, 6'd0, 6'd36, '0, "R7");

        // R6 + R4: advance-and-deposit fills word 2 with 9-bit bytes
        pa = 4'd1; pp = 6'd27;
        for (int k = 0; k < 4; k++) begin
            issue(3'd4, pa, pp, 6'd9, 36'(9'h101 + 9'(k * 37)), "R6");
            pa = last_addr; pp = last_pos;
        end
        issue(3'd1, 4'd2, 6'd0, 6'd36, '0, "R6");
        issue(3'd2, 4'd2, 6'd9, 6'd9, 36'h1FF, "R6");
        issue(3'd1, 4'd2, 6'd0, 6'd36, '0, "R6");

        // R8: undefined op codes
        issue(3'd5, 4'd0, 6'd9, 6'd9, 36'hF_FFFF_FFFF, "R8");
        issue(3'd6, 4'd0, 6'd9, 6'd9, 36'hF_FFFF_FFFF, "R8");
        issue(3'd7, 4'd0, 6'd9, 6'd9, 36'hF_FFFF_FFFF, "R8");
        issue(3'd1, 4'd0, 6'd0, 6'd36, '0, "R8");

        // R9: request while busy is ignored
        issue(3'd2, 4'd7, 6'd0, 6'd9, 36'h55, "R9");
        cmd_op = 3'd2; cmd_addr = 4'd8; cmd_pos = 6'd0; cmd_size = 6'd36;
        cmd_wdata = 36'hA_AAAA_AAAA; cmd_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        issue(3'd1, 4'd8, 6'd0, 6'd36, '0, "R9");
        issue(3'd1, 4'd7, 6'd0, 6'd36, '0, "R9");

        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule